// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 sixteen-bit words. The host offers one word access at a time over a valid/ready handshake. Each offer carries a 17-bit word address, sixteen bits of write data, two byte-lane enables and a direction flag. The controller turns each accepted offer into the active-low strobe sequence the memory needs. It drives chip enable, output enable, write enable and the two byte selects, and it owns a tri-stated sixteen-bit data bus. Read results come back on a response strobe that lasts one cycle.

Every asynchronous interval is a parameter in clock cycles, rounded up from the nanosecond limits at the chosen clock period. The parameters cover read access, write-enable pulse, data setup, address-to-write-end setup and bus float after a read. The defaults suit a 100 MHz clock and the fastest memory grade: 6 read cycles, a 4-cycle write pulse and 2 float cycles. The memory is a plain pin-level peer. The controller has no refresh, no power-down and no burst mode.

The sequencer has six states:
- IDLE: parked in standby, with ready high.
- RD_ACCESS: a read in progress, strobes asserted.
- RD_FLOAT: bus release after a read.
- WR_SETUP: one cycle in which address and selects settle.
- WR_PULSE: write enable held low.
- WR_CLOSE: write enable raised, data still driven.

It has these transitions:
- IDLE to RD_ACCESS on an accepted read.
- IDLE to WR_SETUP on an accepted write.
- RD_ACCESS to RD_FLOAT when the access count expires.
- RD_FLOAT to IDLE when the float count expires.
- WR_SETUP to WR_PULSE after one cycle.
- WR_PULSE to WR_CLOSE when the pulse count expires.
- WR_CLOSE to IDLE after one cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, every memory strobe is high, req_ready is 1 and rsp_valid is 0.
- R2: A read holds mem_ce_n and mem_oe_n low and mem_we_n high for exactly RD_ACCESS_CYC cycles (default 6), starting the cycle after acceptance. mem_oe_n is never low while mem_we_n is low.
- R3: Read data is sampled at the end of the last read-access cycle. rsp_valid is 1 for exactly one cycle, the first RD_FLOAT cycle, and rsp_rdata carries the sampled word in that cycle.
- R4: After a read, all strobes stay high and req_ready stays 0 for FLOAT_CYC cycles (default 2), so at least one idle cycle separates a read from any following write.
- R5: A write is one cycle with mem_ce_n low and mem_we_n high, then exactly PULSE_CYC cycles with mem_we_n low (default 4, the largest of the pulse, data-setup and address-to-end limits), then one cycle with mem_we_n high and mem_ce_n low. mem_oe_n stays high throughout.
- R6: req_be[1] enables the upper lane, data bits 15:8, through mem_ub_n. req_be[0] enables the lower lane, bits 7:0, through mem_lb_n. Each select is driven low for its enabled lane during the whole access. A write leaves the disabled byte unchanged in memory. A read returns 0 in each disabled lane.
- R7: req_ready is 1 only while the controller is idle. A request is accepted only on a clock edge where req_valid and req_ready are both 1. An offer held while busy starts nothing.
- R8: When no access is in progress the memory is in standby: mem_ce_n, mem_ub_n and mem_lb_n are high whenever chip enable is high.
- R9: A word written through the controller and read back returns the written bytes of its enabled lanes.
- R10: mem_addr does not change during any cycle in which mem_ce_n stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller can accept an access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | DATA_W (16) | Read data |
| mem_addr | output | ADDR_W (17) | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq | inout | DATA_W (16) | Bidirectional data bus |

## Verification
Two events can fall in the same cycle. One is a read's data return and the start of its float window. The other is a new offer the host is already holding on req_valid. The bench provokes this by presenting the next request, often a write, while the previous read is still in flight, so the offer stays pending across the capture edge and the float cycles. A reference model predicts every strobe, the address, req_ready and the response for each cycle. The offer is judged correct only if no strobe moves during the float window and the captured word matches what that model holds for the address. The bench's memory model drives garbage until the access time has elapsed, so a capture one cycle early returns a wrong word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_FLOAT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_CLOSE
    } ctrl_state_e;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_be,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [LANES-1:0]  q_be
);

    // Address, data and lane enables are frozen for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_wdata <= '0;
            q_be    <= '0;
        end else if (capture) begin
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
            q_be    <= in_be;
        end
    end

endmodule

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Down counter: a load of N-1 makes the current state last N cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);

    localparam int unsigned LANE_W = DATA_W / LANES;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= capture;
        end
    end

    // Each lane is sampled on its own; a lane that was not selected reads 0.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W          = 17,
    parameter int unsigned DATA_W          = 16,
    parameter int unsigned RD_ACCESS_CYC   = 6,
    parameter int unsigned WE_PULSE_CYC    = 4,
    parameter int unsigned DATA_SETUP_CYC  = 3,
    parameter int unsigned ADDR_TO_END_CYC = 5,
    parameter int unsigned FLOAT_CYC       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int unsigned LANES     = 2;
    // One setup cycle precedes the pulse, so the pulse covers the rest of
    // the address-to-write-end interval.
    localparam int unsigned AE_CYC    = (ADDR_TO_END_CYC > 1) ? ADDR_TO_END_CYC - 1 : 1;
    localparam int unsigned PULSE_CYC = imax(imax(WE_PULSE_CYC, DATA_SETUP_CYC), AE_CYC);
    localparam int unsigned MAX_CYC   = imax(imax(RD_ACCESS_CYC, PULSE_CYC), FLOAT_CYC);
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LOAD    = CNT_W'(RD_ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] FLOAT_LOAD = CNT_W'(FLOAT_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);

    ctrl_state_e       state_q, state_d;
    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              rd_capture;
    logic              dq_drive;
    logic [LANES-1:0]  lanes_n;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [LANES-1:0]  q_be;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign rd_capture = (state_q == ST_RD_ACCESS) && tmr_done;

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_be    (req_be),
        .q_addr   (q_addr),
        .q_wdata  (q_wdata),
        .q_be     (q_be)
    );

    sram_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .lane_en (q_be),
        .bus_in  (mem_dq),
        .rdata   (rsp_rdata),
        .valid   (rsp_valid)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and interval loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    state_d  = ST_RD_FLOAT;
                    tmr_load = 1'b1;
                    tmr_val  = FLOAT_LOAD;
                end
            end
            ST_RD_FLOAT: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_d = ST_WR_CLOSE;
                end
            end
            ST_WR_CLOSE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Pin outputs decoded from the state register only
    always_comb begin
        mem_ce_n = 1'b1;
        mem_oe_n = 1'b1;
        mem_we_n = 1'b1;
        lanes_n  = '1;
        dq_drive = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RD_FLOAT: begin
            end
            ST_RD_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                lanes_n  = ~q_be;
            end
            ST_WR_SETUP, ST_WR_CLOSE: begin
                mem_ce_n = 1'b0;
                lanes_n  = ~q_be;
                dq_drive = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n = 1'b0;
                mem_we_n = 1'b0;
                lanes_n  = ~q_be;
                dq_drive = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr = q_addr;
    assign mem_ub_n = lanes_n[1];
    assign mem_lb_n = lanes_n[0];
    assign mem_dq   = dq_drive ? q_wdata : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned PULSE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n
);

    logic [31:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!mem_we_n) begin
            we_low_cnt <= we_low_cnt + 32'd1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R5

    AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 32'(PULSE_CYC))); // R5

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R2

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3

    AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_ce_n && mem_we_n && !req_ready)); // R4

    AST_READY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n)); // R7

    AST_STANDBY_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_ub_n && mem_lb_n)); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

    localparam int RD_CYC    = 6;
    localparam int PULSE_CYC = 4;
    localparam int FLOAT_CYC = 2;

    typedef struct {
        logic        ce, oe, we, ub, lb, rdy, rv;
        logic [15:0] rd;
        bit          chk_a;
        logic [16:0] a;
        int          tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    wire  [15:0] dq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    exp_t exp_q[$];
    logic [15:0] shadow [int unsigned];
    logic [15:0] mdl_mem [int unsigned];

    always #5 clk = ~clk;

    sram_async_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_ub_n  (mem_ub_n),
        .mem_lb_n  (mem_lb_n),
        .mem_dq    (dq)
    );

    // ---------------- memory model ----------------
    logic        m_lo = 1'b0, m_hi = 1'b0;
    logic [15:0] m_val = '0;
    assign dq[7:0]  = m_lo ? m_val[7:0]  : 8'hzz;
    assign dq[15:8] = m_hi ? m_val[15:8] : 8'hzz;

    function automatic logic [15:0] mdl_get(input logic [16:0] a);
        if (mdl_mem.exists(int'(a))) return mdl_mem[int'(a)];
        return 16'h0000;
    endfunction

    function automatic logic [15:0] sh_get(input logic [16:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return 16'h0000;
    endfunction

    initial begin
        bit          rd_prev = 0, wr_prev = 0;
        int          age = 0;
        logic [16:0] a_prev = '0, wa = '0;
        logic [15:0] wd = '0;
        logic        wub = 1'b1, wlb = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            begin
                bit rd_now, wr_now;
                rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
                wr_now = !mem_ce_n && !mem_we_n && (!mem_ub_n || !mem_lb_n);
                if (rd_now) begin
                    age   = (rd_prev && mem_addr == a_prev) ? age + 1 : 0;
                    m_lo  = !mem_lb_n;
                    m_hi  = !mem_ub_n;
                    m_val = (age >= RD_CYC - 1) ? mdl_get(mem_addr) : 16'hDEAD;
                end else begin
                    age  = 0;
                    m_lo = 1'b0;
                    m_hi = 1'b0;
                end
                if (wr_prev && !wr_now) begin
                    logic [15:0] cur;
                    cur = mdl_get(wa);
                    if (!wlb) cur[7:0]  = wd[7:0];
                    if (!wub) cur[15:8] = wd[15:8];
                    mdl_mem[int'(wa)] = cur;
                end
                if (wr_now) begin
                    wd = dq; wa = mem_addr; wub = mem_ub_n; wlb = mem_lb_n;
                end
                rd_prev = rd_now;
                wr_prev = wr_now;
                a_prev  = mem_addr;
            end
        end
    end

    // ---------------- checking ----------------
    function automatic string tname(input int t);
        case (t)
            2: return "R2";
            4: return "R4";
            5: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !finished) begin
                exp_t e;
                if (exp_q.size() != 0) begin
                    e = exp_q.pop_front();
                end else begin
                    e = '{ce:1'b1, oe:1'b1, we:1'b1, ub:1'b1, lb:1'b1, rdy:1'b1,
                           rv:1'b0, rd:16'h0, chk_a:1'b0, a:17'h0, tag:8};
                end
                chk(mem_ce_n == e.ce, tname(e.tag), "ce_n", 32'(mem_ce_n), 32'(e.ce));
                chk(mem_oe_n == e.oe, tname(e.tag), "oe_n", 32'(mem_oe_n), 32'(e.oe));
                chk(mem_we_n == e.we, tname(e.tag), "we_n", 32'(mem_we_n), 32'(e.we));
                chk(mem_ub_n == e.ub, "R6", "ub_n", 32'(mem_ub_n), 32'(e.ub));
                chk(mem_lb_n == e.lb, "R6", "lb_n", 32'(mem_lb_n), 32'(e.lb));
                chk(req_ready == e.rdy, "R7", "ready", 32'(req_ready), 32'(e.rdy));
                chk(rsp_valid == e.rv, "R3", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
                if (e.rv)
                    chk(rsp_rdata == e.rd, "R9", "rsp_rdata", 32'(rsp_rdata), 32'(e.rd));
                if (e.chk_a)
                    chk(mem_addr == e.a, "R10", "mem_addr", 32'(mem_addr), 32'(e.a));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic push_access(input bit wr, input logic [16:0] a,
                               input logic [15:0] d, input logic [1:0] be);
        exp_t e;
        e = '{ce:1'b0, oe:1'b1, we:1'b1, ub:!be[1], lb:!be[0], rdy:1'b0,
               rv:1'b0, rd:16'h0, chk_a:1'b1, a:a, tag:5};
        if (wr) begin
            logic [15:0] cur;
            exp_q.push_back(e);                         // setup
            e.we = 1'b0;
            for (int i = 0; i < PULSE_CYC; i++) exp_q.push_back(e);
            e.we = 1'b1;
            exp_q.push_back(e);                         // close
            cur = sh_get(a);
            if (be[0]) cur[7:0]  = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            shadow[int'(a)] = cur;
        end else begin
            logic [15:0] w;
            e.oe = 1'b0; e.tag = 2;
            for (int i = 0; i < RD_CYC; i++) exp_q.push_back(e);
            w = sh_get(a);
            e = '{ce:1'b1, oe:1'b1, we:1'b1, ub:1'b1, lb:1'b1, rdy:1'b0,
                  rv:1'b1, rd:{be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00},
                  chk_a:1'b0, a:17'h0, tag:4};
            for (int i = 0; i < FLOAT_CYC; i++) begin
                exp_q.push_back(e);
                e.rv = 1'b0;
            end
        end
    endtask

    // Offer stays asserted while the controller is busy (R7).
    task automatic issue(input bit wr, input logic [16:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        push_access(wr, a, d, be);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1", "strobes in reset",
            32'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1f);
        chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(1'b1, 17'h00010, 16'h1234, 2'b11);   // R5 R9 full word
        issue(1'b0, 17'h00010, 16'h0000, 2'b11);   // R2 R3 R4
        issue(1'b1, 17'h00010, 16'hAB00, 2'b10);   // R6 upper only
        issue(1'b0, 17'h00010, 16'h0000, 2'b01);   // R6 lower lane read, upper zero
        issue(1'b0, 17'h00010, 16'h0000, 2'b11);   // R6 merge 0xAB34
        issue(1'b1, 17'h1FFFF, 16'hFFCD, 2'b01);   // top address, lower only
        issue(1'b0, 17'h1FFFF, 16'h0000, 2'b11);   // R9 0x00CD
        issue(1'b1, 17'h00010, 16'h5555, 2'b00);   // R6 no lane: memory unchanged
        issue(1'b0, 17'h00010, 16'h0000, 2'b11);
        issue(1'b0, 17'h00010, 16'h0000, 2'b00);   // R6 no lane read returns 0
        issue(1'b1, 17'h00020, 16'hBEEF, 2'b11);   // write right after read (R4)
        issue(1'b1, 17'h00021, 16'hCAFE, 2'b11);   // back-to-back writes
        issue(1'b0, 17'h00020, 16'h0000, 2'b11);
        issue(1'b0, 17'h00021, 16'h0000, 2'b11);

        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[2], 17'h00100 + 17'(lfsr[5:3]), lfsr ^ 16'(i * 16'h0913), lfsr[1:0]);
        end
        for (int i = 0; i < 8; i++) issue(1'b0, 17'h00100 + 17'(i), 16'h0, 2'b11);

        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "pending expectations", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule